// File: doc/BRIEF.md
# Prescaled Periodic Timer

This block is a periodic interval timer whose main counter is extended downward by a prescaler, so the pair {counter, prescaler} behaves as one wide count. The prescaler holds the low-order part: with prescale value N, the main counter moves one step every N+1 clocks. The timer counts either down to zero or up from zero to a programmed end point. It raises a one-clock time-out pulse once per period and a one-clock match pulse when the count equals a programmed match pair.

Load, prescale, match and prescale-match values each have a written copy and an in-use copy. Software chooses per group whether a write takes effect on the next clock or waits for the next time-out. A direct write of the whole count is always taken on the next clock. At each time-out the block can latch the count into snapshot registers while the live count stays readable. It also drives one output pin with a programmable action. A debug-halt input can freeze counting unless a real-time override is set.

Top module: `prescaled_period_timer`

## Requirements
- R1: With load L and prescale P, the time-out pulse repeats every (L+1)*(P+1) clocks while counting runs undisturbed, and each time-out is a single-cycle pulse on `timeout_o`.
- R2: Counting down, the prescaler steps down each enabled clock; when it is 0, it reloads P and the counter decrements. A time-out occurs in the cycle where both are 0, and on the next clock the pair reloads from the written load and prescale values.
- R3: Counting up, the prescaler steps up to P, then returns to 0 while the counter increments. A time-out occurs in the cycle where the pair equals (in-use load, in-use prescale), and on the next clock the pair restarts at 0.
- R4: With `ld_defer`=0, a load or prescale write takes effect on the next clock. Counting down, it also overwrites the matching half of the count (counter or prescaler). Counting up, it only moves the end point.
- R5: With `ld_defer`=1, a load or prescale write changes neither the count nor the end point until the next time-out, where it becomes the in-use value.
- R6: A write on `value_wr` places `value_data` (counter in the upper CNT_W bits, prescaler in the lower PRE_W bits) into the count on the next clock in either direction, ahead of every other update.
- R7: `match_o` pulses in each enabled cycle where the count equals the in-use (match, prescale-match) pair. With `match_defer`=0, a match write is in use from the next clock.
- R8: With `match_defer`=1, match and prescale-match writes come into use only at the next time-out.
- R9: When `snap_en`=1, each time-out latches the counter into `snap_cnt_o` and the prescaler into `snap_pre_o`. Otherwise both hold their values. `free_val_o` always shows the live count.
- R10: At each time-out, `pin_act` acts on `pin_o` from the next clock: 00 no change, 01 toggle, 10 drive 0, 11 drive 1.
- R11: With `stall_en`=1 and `rtc_en`=0, asserting `dbg_halt` freezes the count and suppresses time-out and match pulses until release. With `rtc_en`=1, `dbg_halt` has no effect.
- R12: After reset the count, snapshots and pin are 0. Load and match are all ones, prescale is 0 and prescale-match is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counting enable |
| count_up | input | 1 | 1 counts up, 0 counts down |
| ld_defer | input | 1 | Defer load/prescale writes to the next time-out |
| match_defer | input | 1 | Defer match/prescale-match writes to the next time-out |
| snap_en | input | 1 | Latch the count at time-out |
| stall_en | input | 1 | Allow debug halt to freeze counting |
| rtc_en | input | 1 | Real-time override of the stall |
| dbg_halt | input | 1 | Debug halt indication |
| pin_act | input | 2 | Pin action at time-out |
| load_wr | input | 1 | Load value write strobe |
| load_data | input | CNT_W | Load value |
| pscl_wr | input | 1 | Prescale write strobe |
| pscl_data | input | PRE_W | Prescale value |
| value_wr | input | 1 | Direct count write strobe |
| value_data | input | CNT_W+PRE_W | Count value, counter in upper bits |
| match_wr | input | 1 | Match write strobe |
| match_data | input | CNT_W | Match value |
| pmatch_wr | input | 1 | Prescale-match write strobe |
| pmatch_data | input | PRE_W | Prescale-match value |
| timeout_o | output | 1 | Time-out pulse |
| match_o | output | 1 | Match pulse |
| pin_o | output | 1 | Action-driven output pin |
| free_val_o | output | CNT_W+PRE_W | Live count |
| snap_cnt_o | output | CNT_W | Counter snapshot |
| snap_pre_o | output | PRE_W | Prescaler snapshot |

## Verification
The bench builds the timer with CNT_W=6 and PRE_W=3. Every prescale value from 0 to the maximum of 7 then fits in short runs, and whole periods, including counter wrap after the end point is lowered below the count, finish within tens to a few hundred clocks. With these widths, deferred and immediate updates, snapshots and pin actions can each be watched across several time-outs without long waits.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;
endpackage

// File: rtl/ptm_shadow_reg.sv
// Written copy plus in-use copy of one programmable value.
module ptm_shadow_reg #(
  parameter int W        = 16,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         defer,
  input  logic         commit,
  output logic [W-1:0] shadow_q,
  output logic [W-1:0] active_q
);
  localparam logic [W-1:0] RST_VAL = {W{RST_ONES}};

  logic imm_take;
  assign imm_take = wr && !defer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      if (wr) shadow_q <= wdata;
      if (imm_take)    active_q <= wdata;
      else if (commit) active_q <= shadow_q;
    end
  end

  // R5 / R8: a deferred write leaves the in-use copy alone until commit
  p_defer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && defer && !commit) |=> (active_q == $past(active_q)));
  // R5 / R8: commit moves the written copy into use
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr) |=> (active_q == $past(shadow_q)));
  // R4 / R7: an immediate write is in use on the next clock
  p_immediate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !defer) |=> (active_q == $past(wdata)));
endmodule

// File: rtl/ptm_counter.sv
// Combined counter + prescaler with reload, step and forced loads.
module ptm_counter #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  localparam int TOT_W = CNT_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             count_up,
  input  logic             val_wr,
  input  logic [TOT_W-1:0] val_data,
  input  logic             force_en,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             ps_wr,
  input  logic [PRE_W-1:0] ps_val,
  input  logic [CNT_W-1:0] ld_act,
  input  logic [PRE_W-1:0] ps_act,
  input  logic [CNT_W-1:0] ld_sh,
  input  logic [PRE_W-1:0] ps_sh,
  output logic [CNT_W-1:0] cnt_q,
  output logic [PRE_W-1:0] pre_q,
  output logic             at_end,
  output logic             timeout
);
  function automatic logic [TOT_W-1:0] step_down(
    input logic [CNT_W-1:0] c, input logic [PRE_W-1:0] p,
    input logic [PRE_W-1:0] p_reload);
    if (p == '0) return {c - 1'b1, p_reload};
    return {c, p - 1'b1};
  endfunction

  function automatic logic [TOT_W-1:0] step_up(
    input logic [CNT_W-1:0] c, input logic [PRE_W-1:0] p,
    input logic [PRE_W-1:0] p_limit);
    if (p == p_limit) return {c + 1'b1, {PRE_W{1'b0}}};
    return {c, p + 1'b1};
  endfunction

  function automatic logic reached_end(
    input logic up, input logic [CNT_W-1:0] c, input logic [PRE_W-1:0] p,
    input logic [CNT_W-1:0] l, input logic [PRE_W-1:0] pl);
    if (up) return (c == l) && (p == pl);
    return (c == '0) && (p == '0);
  endfunction

  logic [TOT_W-1:0] nxt;
  logic             forced;

  assign at_end  = reached_end(count_up, cnt_q, pre_q, ld_act, ps_act);
  assign timeout = run && at_end;
  assign forced  = force_en && (ld_wr || ps_wr);

  always_comb begin
    nxt = {cnt_q, pre_q};
    if (val_wr) begin
      nxt = val_data;
    end else if (forced) begin
      nxt = {(ld_wr ? ld_val : cnt_q), (ps_wr ? ps_val : pre_q)};
    end else if (run) begin
      if (at_end) nxt = count_up ? {TOT_W{1'b0}} : {ld_sh, ps_sh};
      else if (count_up) nxt = step_up(cnt_q, pre_q, ps_act);
      else nxt = step_down(cnt_q, pre_q, ps_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {cnt_q, pre_q} <= '0;
    else        {cnt_q, pre_q} <= nxt;
  end

  // R2: down-count reload from the written load/prescale values
  p_down_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !count_up && !val_wr && !forced) |=> ({cnt_q, pre_q} == $past({ld_sh, ps_sh})));
  // R3: up-count restarts at zero after time-out
  p_up_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && count_up && !val_wr && !forced) |=> ({cnt_q, pre_q} == '0));
  // R6: direct value write wins on the next clock
  p_value_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> ({cnt_q, pre_q} == $past(val_data)));
  // R11: no run and no write means the count holds
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !val_wr && !forced) |=> $stable({cnt_q, pre_q}));
endmodule

// File: rtl/ptm_pin_action.sv
module ptm_pin_action
  import ptm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fire,
  input  pin_act_e act,
  output logic     pin_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else if (fire) begin
      unique case (act)
        ACT_TOGGLE: pin_q <= !pin_q;
        ACT_CLEAR:  pin_q <= 1'b0;
        ACT_SET:    pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_TOGGLE) |=> (pin_q != $past(pin_q)));
  p_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && act == ACT_SET) |=> pin_q);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire || act == ACT_NONE) |=> $stable(pin_q));
endmodule

// File: rtl/prescaled_period_timer.sv
module prescaled_period_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  localparam int TOT_W = CNT_W + PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             count_up,
  input  logic             ld_defer,
  input  logic             match_defer,
  input  logic             snap_en,
  input  logic             stall_en,
  input  logic             rtc_en,
  input  logic             dbg_halt,
  input  logic [1:0]       pin_act,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             pscl_wr,
  input  logic [PRE_W-1:0] pscl_data,
  input  logic             value_wr,
  input  logic [TOT_W-1:0] value_data,
  input  logic             match_wr,
  input  logic [CNT_W-1:0] match_data,
  input  logic             pmatch_wr,
  input  logic [PRE_W-1:0] pmatch_data,
  output logic             timeout_o,
  output logic             match_o,
  output logic             pin_o,
  output logic [TOT_W-1:0] free_val_o,
  output logic [CNT_W-1:0] snap_cnt_o,
  output logic [PRE_W-1:0] snap_pre_o
);
  logic             frozen, tick, at_end, force_ld;
  logic [CNT_W-1:0] ld_sh, ld_act, m_sh, m_act, cnt_q;
  logic [PRE_W-1:0] ps_sh, ps_act, pm_sh, pm_act, pre_q;

  assign frozen   = stall_en && !rtc_en && dbg_halt;
  assign tick     = run_en && !frozen;
  assign force_ld = !ld_defer && !count_up;

  ptm_shadow_reg #(.W(CNT_W), .RST_ONES(1'b1)) u_load (
    .clk, .rst_n, .wr(load_wr), .wdata(load_data), .defer(ld_defer),
    .commit(timeout_o), .shadow_q(ld_sh), .active_q(ld_act));
  ptm_shadow_reg #(.W(PRE_W), .RST_ONES(1'b0)) u_pscl (
    .clk, .rst_n, .wr(pscl_wr), .wdata(pscl_data), .defer(ld_defer),
    .commit(timeout_o), .shadow_q(ps_sh), .active_q(ps_act));
  ptm_shadow_reg #(.W(CNT_W), .RST_ONES(1'b1)) u_match (
    .clk, .rst_n, .wr(match_wr), .wdata(match_data), .defer(match_defer),
    .commit(timeout_o), .shadow_q(m_sh), .active_q(m_act));
  ptm_shadow_reg #(.W(PRE_W), .RST_ONES(1'b1)) u_pmatch (
    .clk, .rst_n, .wr(pmatch_wr), .wdata(pmatch_data), .defer(match_defer),
    .commit(timeout_o), .shadow_q(pm_sh), .active_q(pm_act));

  ptm_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk, .rst_n, .run(tick), .count_up,
    .val_wr(value_wr), .val_data(value_data), .force_en(force_ld),
    .ld_wr(load_wr), .ld_val(load_data), .ps_wr(pscl_wr), .ps_val(pscl_data),
    .ld_act, .ps_act, .ld_sh, .ps_sh,
    .cnt_q, .pre_q, .at_end, .timeout(timeout_o));

  ptm_pin_action u_pin (
    .clk, .rst_n, .fire(timeout_o), .act(pin_act_e'(pin_act)), .pin_q(pin_o));

  assign match_o    = tick && (cnt_q == m_act) && (pre_q == pm_act);
  assign free_val_o = {cnt_q, pre_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_cnt_o <= '0;
      snap_pre_o <= '0;
    end else if (timeout_o && snap_en) begin
      snap_cnt_o <= cnt_q;
      snap_pre_o <= pre_q;
    end
  end

  // R9: snapshot captures the count seen at time-out
  p_snap_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && snap_en) |=> ({snap_cnt_o, snap_pre_o} == $past(free_val_o)));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeout_o && snap_en) |=> $stable({snap_cnt_o, snap_pre_o}));
  // R11: a stalled halt suppresses pulses
  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && !rtc_en && dbg_halt) |-> (!timeout_o && !match_o));
  // R8: match pair committed at time-out when no write collides
  p_match_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !match_wr && !pmatch_wr) |=> ({m_act, pm_act} == $past({m_sh, pm_sh})));
  // R2: time-out while counting down only at zero
  p_down_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !count_up) |-> (free_val_o == '0));
endmodule

// File: tb/prescaled_period_timer_tb_top.sv
`timescale 1ns/1ps
module prescaled_period_timer_tb_top;
  localparam int CW   = 6;
  localparam int PW   = 3;
  localparam int TW   = CW + PW;
  localparam int CMOD = 1 << CW;
  localparam int PMOD = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 0, count_up = 0, ld_defer = 0, match_defer = 0, snap_en = 0;
  logic stall_en = 0, rtc_en = 0, dbg_halt = 0;
  logic [1:0] pin_act = 2'b00;
  logic load_wr = 0, pscl_wr = 0, value_wr = 0, match_wr = 0, pmatch_wr = 0;
  logic [CW-1:0] load_data = '0, match_data = '0;
  logic [PW-1:0] pscl_data = '0, pmatch_data = '0;
  logic [TW-1:0] value_data = '0;
  logic timeout_o, match_o, pin_o;
  logic [TW-1:0] free_val_o;
  logic [CW-1:0] snap_cnt_o;
  logic [PW-1:0] snap_pre_o;

  always #2.5 clk = ~clk;

  prescaled_period_timer #(.CNT_W(CW), .PRE_W(PW)) dut_i (
    .clk, .rst_n, .run_en, .count_up, .ld_defer, .match_defer, .snap_en,
    .stall_en, .rtc_en, .dbg_halt, .pin_act, .load_wr, .load_data,
    .pscl_wr, .pscl_data, .value_wr, .value_data, .match_wr, .match_data,
    .pmatch_wr, .pmatch_data, .timeout_o, .match_o, .pin_o, .free_val_o,
    .snap_cnt_o, .snap_pre_o);

  int vecs = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R12";

  task automatic check_int(input int act, input int exp, input string tag);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt = 0, m_pre = 0, m_pin = 0, m_sc = 0, m_sp = 0;
  int ld_w = CMOD-1, ld_u = CMOD-1, ps_w = 0, ps_u = 0;
  int mt_w = CMOD-1, mt_u = CMOD-1, pm_w = PMOD-1, pm_u = PMOD-1;

  always @(negedge clk) begin
    if (rst_n) begin
      bit halted, go, fin, exp_to, exp_mh;
      int nc, np, v_in;
      halted = stall_en && !rtc_en && dbg_halt;
      go     = run_en && !halted;
      fin    = count_up ? (m_cnt == ld_u && m_pre == ps_u) : (m_cnt == 0 && m_pre == 0);
      exp_to = go && fin;
      exp_mh = go && m_cnt == mt_u && m_pre == pm_u;
      check_int(int'(timeout_o), int'(exp_to), {cur_req, " timeout"});
      check_int(int'(match_o), int'(exp_mh), {cur_req, " match"});
      check_int(int'(pin_o), m_pin, {cur_req, " pin"});
      check_int(int'(free_val_o), m_cnt * PMOD + m_pre, {cur_req, " count"});
      check_int(int'(snap_cnt_o) * PMOD + int'(snap_pre_o), m_sc * PMOD + m_sp, {cur_req, " snapshot"});
      // next count
      nc = m_cnt; np = m_pre; v_in = int'(value_data);
      if (value_wr) begin
        nc = v_in / PMOD; np = v_in % PMOD;
      end else if (!ld_defer && !count_up && (load_wr || pscl_wr)) begin
        if (load_wr) nc = int'(load_data);
        if (pscl_wr) np = int'(pscl_data);
      end else if (go) begin
        if (fin) begin
          if (count_up) begin nc = 0; np = 0; end
          else begin nc = ld_w; np = ps_w; end
        end else if (count_up) begin
          if (m_pre == ps_u) begin np = 0; nc = (m_cnt + 1) % CMOD; end
          else np = m_pre + 1;
        end else begin
          if (m_pre == 0) begin np = ps_u; nc = (m_cnt + CMOD - 1) % CMOD; end
          else np = m_pre - 1;
        end
      end
      if (exp_to && snap_en) begin m_sc = m_cnt; m_sp = m_pre; end
      if (exp_to) begin
        case (pin_act)
          2'b01: m_pin = 1 - m_pin;
          2'b10: m_pin = 0;
          2'b11: m_pin = 1;
          default: ;
        endcase
      end
      // in-use copies, then written copies
      if (load_wr && !ld_defer) ld_u = int'(load_data); else if (exp_to) ld_u = ld_w;
      if (pscl_wr && !ld_defer) ps_u = int'(pscl_data); else if (exp_to) ps_u = ps_w;
      if (match_wr && !match_defer) mt_u = int'(match_data); else if (exp_to) mt_u = mt_w;
      if (pmatch_wr && !match_defer) pm_u = int'(pmatch_data); else if (exp_to) pm_u = pm_w;
      if (load_wr) ld_w = int'(load_data);
      if (pscl_wr) ps_w = int'(pscl_data);
      if (match_wr) mt_w = int'(match_data);
      if (pmatch_wr) pm_w = int'(pmatch_data);
      m_cnt = nc; m_pre = np;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_load(input int v);
    load_wr = 1; load_data = CW'(v); cyc(1); load_wr = 0;
  endtask
  task automatic wr_pscl(input int v);
    pscl_wr = 1; pscl_data = PW'(v); cyc(1); pscl_wr = 0;
  endtask
  task automatic wr_value(input int c, input int p, input string tag);
    value_wr = 1; value_data = TW'(c * PMOD + p); cyc(1); value_wr = 0;
    check_int(int'(free_val_o), c * PMOD + p, tag);
  endtask

  task automatic measure_period(input int exp, input string tag);
    int n;
    @(negedge clk);
    while (!timeout_o) @(negedge clk);
    @(negedge clk);
    n = 1;
    while (!timeout_o) begin @(negedge clk); n++; end
    check_int(n, exp, tag);
    @(posedge clk); #1;
  endtask

  initial begin
    int held;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R12: reset state
    check_int(int'(free_val_o), 0, "R12 count");
    check_int(int'(pin_o), 0, "R12 pin");
    check_int(int'(snap_cnt_o) + int'(snap_pre_o), 0, "R12 snapshot");
    check_int(int'(timeout_o), 0, "R12 timeout");

    // R2 / R1: down counting with prescale
    cur_req = "R2";
    wr_load(5); wr_pscl(2);
    run_en = 1; cyc(40);
    measure_period(18, "R1 period L5 P2");
    wr_load(1); wr_pscl(7);
    measure_period(16, "R1 period L1 P7 (max prescale)");

    // R3: up counting
    cur_req = "R3";
    run_en = 0; count_up = 1;
    wr_value(0, 0, "R6 value write up");
    wr_load(4); wr_pscl(1);
    run_en = 1; cyc(30);
    measure_period(10, "R3 period up L4 P1");

    // R4: immediate updates
    cur_req = "R4";
    wr_value(0, 0, "R6 value write up");
    wr_load(2);
    measure_period(6, "R4 up end point moved");
    count_up = 0;
    wr_load(9);
    check_int(int'(free_val_o) / PMOD, 9, "R4 down load forced");
    cyc(4);
    wr_pscl(3);
    check_int(int'(free_val_o) % PMOD, 3, "R4 down prescale forced");
    cyc(30);

    // R5: deferred updates
    cur_req = "R5";
    ld_defer = 1;
    held = int'(free_val_o);
    wr_load(3);
    check_int(int'(free_val_o), held - 1, "R5 deferred load leaves count");
    cyc(60);
    measure_period(16, "R5 period after commit");
    count_up = 1;
    wr_value(0, 0, "R6 value write up");
    wr_load(5);
    cyc(60);

    // R6: direct count writes in both directions
    cur_req = "R6";
    wr_value(2, 1, "R6 up");
    cyc(10);
    count_up = 0;
    wr_value(4, 0, "R6 down");
    cyc(20);

    // R7 / R8: match
    cur_req = "R7";
    ld_defer = 0;
    wr_load(6); wr_pscl(1);
    match_wr = 1; match_data = 3; pmatch_wr = 1; pmatch_data = 0;
    cyc(1); match_wr = 0; pmatch_wr = 0;
    cyc(40);
    cur_req = "R8";
    match_defer = 1;
    match_wr = 1; match_data = 5; pmatch_wr = 1; pmatch_data = 1;
    cyc(1); match_wr = 0; pmatch_wr = 0;
    cyc(40);

    // R9: snapshot
    cur_req = "R9";
    snap_en = 1; count_up = 1;
    wr_value(0, 0, "R6 value write up");
    cyc(40);
    check_int(int'(snap_cnt_o) * PMOD + int'(snap_pre_o), 6 * PMOD + 1, "R9 snapshot at end point");
    snap_en = 0;
    wr_load(3);
    cyc(30);
    check_int(int'(snap_cnt_o) * PMOD + int'(snap_pre_o), 6 * PMOD + 1, "R9 snapshot held when disabled");

    // R10: pin actions
    cur_req = "R10";
    for (int a = 3; a >= 0; a--) begin
      pin_act = 2'(a); cyc(20);
    end
    pin_act = 2'b01; cyc(25);

    // R11: debug freeze
    cur_req = "R11";
    stall_en = 1; dbg_halt = 1;
    held = int'(free_val_o);
    cyc(8);
    check_int(int'(free_val_o), held, "R11 frozen while halted");
    dbg_halt = 0; cyc(15);
    rtc_en = 1; dbg_halt = 1;
    held = int'(free_val_o);
    cyc(3);
    check_int(int'(free_val_o) != held ? 1 : 0, 1, "R11 override keeps counting");
    cyc(20);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule